// File: doc/BRIEF.md
# Opcode-Driven SPI Transfer Sequencer

This block is a half-duplex SPI master. A host does not drive the serial bus one byte at a time. It loads a 64-bit program word made of up to eight one-byte opcodes. The opcodes assert or release a chip select, shift bytes out of a 64-bit transmit register, shift bytes into a 64-bit receive register, branch back under a loop count, and stop. Execution begins with the most significant byte of the word.

Data moves through single-entry transmit and receive registers, each with a full flag. When the program needs transmit data that has not been written yet, it waits. It also waits when received bytes are ready but the host has not yet read the previous receive value. So the host controls the pace of the transfer by polling the status word, writing transmit data and reading receive data. The SCK rate comes from a divider field in the clock configuration register. A write of two specific patterns to that register, one after the other, returns the block to a clean state.

The host port is a simple register interface. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address, and the side effects of a read (clearing receive-full or flagging underrun) occur on the edge where the read strobe is high.

Top module: `spi_seq_top`

## Requirements
- R1: Register addresses are 0 counter configuration, 1 clock configuration, 2 TX data, 3 RX data, 4 sequence word, 5 status. After reset, the status reads 0x0001_0000_0000_0000 (only the idle bit 48 set), every csN line is high and sck is low.
- R2: A TX data write to an empty register stores the value and sets TX-full (status bit 59). A TX write while TX-full is set leaves the stored value unchanged and sets the sticky TX-overrun flag (bit 58).
- R3: Reading RX data while RX-full (bit 63) is set clears RX-full. Reading it while RX-full is clear sets the sticky RX-underrun flag (bit 61).
- R4: Opcode 0x1N with N from 1 to CS_COUNT drives csN[N-1] low and the other lines high. With N = 0 or N above CS_COUNT, all lines go high.
- R5: Opcode 0x3N consumes the TX register, clearing TX-full, and shifts N bytes out on mosi most significant bit first, starting from TX bit 63. N = 0 and N = 9..15 mean 8 bytes. mosi changes only while sck is low.
- R6: If a shift-out opcode is reached while TX-full is clear, the sequencer holds with no sck activity until TX data is written.
- R7: Opcode 0x4N samples N bytes (same length rule as R5) on sck rising edges, right-aligned so that the last bit lands in bit 0 with zeros above. It loads them into RX data and sets RX-full. If RX-full is still set when the bytes are ready, the sequencer waits until the host reads RX.
- R8: Starting a program loads the loop count from counter configuration bits 39:32. Opcode 0xEN with a nonzero count decrements the count and jumps to index N mod 8. With a zero count it falls through.
- R9: Opcodes run from index 0 (bits 63:56) to index 7 (bits 7:0). Opcode 0x00 returns the sequencer to idle. Finishing index 7 without a stop also returns it to idle. Neither changes csN.
- R10: Each sck high phase and each low phase lasts DIV+1 clock cycles, where DIV is clock configuration bits 63:52. Clock configuration bit 51 set samples miso at the sck rising edge; bit 51 clear samples it one clock cycle later.
- R11: A clock configuration write with bits 36 and 38 set, followed by one with bits 37 and 39 set, stops the program and the shifter. It clears all status flags and drives every csN high. The second write alone has no such effect.
- R12: A sequence word write while the sequencer is busy is ignored. The stored word reads back unchanged.
- R13: Opcodes whose upper nibble is not 0x1, 0x3, 0x4 or 0xE, and 0x01..0x0F, do nothing and execution continues at the next index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (for read side effects) |
| regAddr | input | 3 | Register address |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data (combinational from regAddr) |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| csN | output | CS_COUNT | Active-low chip selects |

## Verification
The assertions check on every cycle the properties that hold at all times: at most one chip select is active, sck is low when the sequencer is idle, mosi does not change while sck is high, and TX-overrun stays set once raised. They also check that TX-full falls and RX-full rises only while a program runs, and that the reset pair releases every select. The directed scenarios are needed for the rest. These cover the bit order on the wire, right-alignment of received bytes, loop counts, stalls on an empty TX or a full RX, the implicit stop after index 7, and the measured sck phase length. Each of these needs a full program run with known data.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int WORD_W = 64;
  localparam int DIV_W  = 12;

  localparam logic [2:0] ADDR_CNT  = 3'd0;
  localparam logic [2:0] ADDR_CLK  = 3'd1;
  localparam logic [2:0] ADDR_TX   = 3'd2;
  localparam logic [2:0] ADDR_RX   = 3'd3;
  localparam logic [2:0] ADDR_SEQ  = 3'd4;
  localparam logic [2:0] ADDR_STAT = 3'd5;

  localparam logic [3:0] GRP_STOP = 4'h0;
  localparam logic [3:0] GRP_SEL  = 4'h1;
  localparam logic [3:0] GRP_OUT  = 4'h3;
  localparam logic [3:0] GRP_IN   = 4'h4;
  localparam logic [3:0] GRP_BRA  = 4'hE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_SHIFT,
    ST_RXWAIT
  } seqState_t;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic       consumeTx;
    logic       startShift;
    logic       shiftIn;
    logic [3:0] nBytes;
    logic       commitRx;
  } seqCmd_t;
endpackage

// File: rtl/spi_seq_dp.sv
module spi_seq_dp
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  seqCmd_t           cmd,
  input  logic              seqIdle,
  output logic              txFull,
  output logic              rxFull,
  output logic              txOvr,
  output logic              shiftDone,
  output logic              seqWr,
  output logic              softRst,
  output logic [WORD_W-1:0] seqWord,
  output logic [7:0]        loopInit,
  input  logic              miso,
  output logic              sck,
  output logic              mosi
);
  localparam int BITS_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] cntCfg, clkCfg, txData, rxData, seqReg;
  logic              rxUnd, armed;
  logic              wrCnt, wrClk, wrTx, wrSeq, rdRx;
  logic [DIV_W-1:0]  divVal, divCnt;
  logic              noDelay;

  logic              shActive, shIn, sckQ, samplePend;
  logic [BITS_W-1:0] shBits;
  logic [WORD_W-1:0] shReg, rxShift;
  logic              tick;

  assign wrCnt = regWr && (regAddr == ADDR_CNT);
  assign wrClk = regWr && (regAddr == ADDR_CLK);
  assign wrTx  = regWr && (regAddr == ADDR_TX);
  assign wrSeq = regWr && (regAddr == ADDR_SEQ);
  assign rdRx  = regRd && (regAddr == ADDR_RX);

  assign softRst  = wrClk && armed && regWrData[37] && regWrData[39];
  assign seqWr    = wrSeq && seqIdle;
  assign seqWord  = seqReg;
  assign loopInit = cntCfg[39:32];
  assign divVal   = clkCfg[63:52];
  assign noDelay  = clkCfg[51];

  // Configuration and program storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntCfg <= '0;
      clkCfg <= '0;
      seqReg <= '0;
      armed  <= 1'b0;
    end else begin
      if (wrCnt) cntCfg <= regWrData;
      if (wrClk) begin
        clkCfg <= regWrData;
        armed  <= regWrData[36] && regWrData[38];
      end
      if (seqWr) seqReg <= regWrData;
    end
  end

  // Transmit holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= '0;
      txFull <= 1'b0;
      txOvr  <= 1'b0;
    end else if (softRst) begin
      txFull <= 1'b0;
      txOvr  <= 1'b0;
    end else begin
      if (cmd.consumeTx) txFull <= 1'b0;
      if (wrTx) begin
        if (txFull) begin
          txOvr <= 1'b1;
        end else begin
          txData <= regWrData;
          txFull <= 1'b1;
        end
      end
    end
  end

  // Receive holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxFull <= 1'b0;
      rxUnd  <= 1'b0;
    end else if (softRst) begin
      rxFull <= 1'b0;
      rxUnd  <= 1'b0;
    end else begin
      if (rdRx) begin
        if (rxFull) rxFull <= 1'b0;
        else        rxUnd  <= 1'b1;
      end
      if (cmd.commitRx) begin
        rxData <= rxShift;
        rxFull <= 1'b1;
      end
    end
  end

  // Shift engine, SPI mode 0
  assign tick      = shActive && (divCnt == divVal);
  assign shiftDone = tick && sckQ && (shBits == BITS_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shActive   <= 1'b0;
      shIn       <= 1'b0;
      sckQ       <= 1'b0;
      samplePend <= 1'b0;
      shBits     <= '0;
      shReg      <= '0;
      rxShift    <= '0;
      divCnt     <= '0;
    end else if (softRst) begin
      shActive   <= 1'b0;
      sckQ       <= 1'b0;
      samplePend <= 1'b0;
      divCnt     <= '0;
    end else begin
      if (samplePend) begin
        rxShift    <= {rxShift[WORD_W-2:0], miso};
        samplePend <= 1'b0;
      end
      if (cmd.startShift) begin
        shActive <= 1'b1;
        shIn     <= cmd.shiftIn;
        shBits   <= BITS_W'({cmd.nBytes, 3'b000});
        shReg    <= cmd.shiftIn ? '0 : txData;
        rxShift  <= '0;
        divCnt   <= '0;
        sckQ     <= 1'b0;
      end else if (shActive) begin
        if (tick) begin
          divCnt <= '0;
          sckQ   <= !sckQ;
          if (!sckQ) begin
            if (shIn) begin
              if (noDelay) rxShift    <= {rxShift[WORD_W-2:0], miso};
              else         samplePend <= 1'b1;
            end
          end else begin
            shReg  <= {shReg[WORD_W-2:0], 1'b0};
            shBits <= shBits - BITS_W'(1);
            if (shBits == BITS_W'(1)) shActive <= 1'b0;
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign sck  = sckQ;
  assign mosi = shActive && !shIn && shReg[WORD_W-1];

  // Register read mux
  always_comb begin
    unique case (regAddr)
      ADDR_CNT:  regRdData = cntCfg;
      ADDR_CLK:  regRdData = clkCfg;
      ADDR_TX:   regRdData = txData;
      ADDR_RX:   regRdData = rxData;
      ADDR_SEQ:  regRdData = seqReg;
      ADDR_STAT: regRdData = {rxFull, 1'b0, rxUnd, 1'b0, txFull, txOvr, 1'b0, 1'b0,
                              6'b0, !seqIdle, seqIdle, 48'b0};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int CS_COUNT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softRst,
  input  logic                seqWr,
  input  logic [WORD_W-1:0]   seqWord,
  input  logic [7:0]          loopInit,
  input  logic                txFull,
  input  logic                rxFull,
  input  logic                shiftDone,
  output seqCmd_t             cmd,
  output logic                seqIdle,
  output logic [CS_COUNT-1:0] csN
);
  seqState_t           state, stateN;
  logic [2:0]          pc, pcN, advPc;
  seqState_t           advState;
  logic [7:0]          loopCnt, loopN;
  logic                inDir, inDirN;
  logic [CS_COUNT-1:0] csReg, csNext, csDecode;
  logic [5:0]          opBase;
  logic [7:0]          op;
  logic [3:0]          nb;

  assign opBase = {3'd7 - pc, 3'b000};
  assign op     = seqWord[opBase +: 8];
  assign nb     = ((op[3:0] == 4'd0) || (op[3:0] > 4'd8)) ? 4'd8 : op[3:0];

  // One decoder per select line
  for (genvar g = 0; g < CS_COUNT; g++) begin : g_csDec
    assign csDecode[g] = !(op[3:0] == 4'(g + 1));
  end

  // Next index, or idle after the last slot
  always_comb begin
    if (pc == 3'd7) begin
      advState = ST_IDLE;
      advPc    = 3'd0;
    end else begin
      advState = ST_EXEC;
      advPc    = pc + 3'd1;
    end
  end

  always_comb begin
    stateN = state;
    pcN    = pc;
    loopN  = loopCnt;
    inDirN = inDir;
    csNext = csReg;
    cmd    = '0;
    unique case (state)
      ST_IDLE: begin
        if (seqWr) begin
          stateN = ST_EXEC;
          pcN    = 3'd0;
          loopN  = loopInit;
        end
      end
      ST_EXEC: begin
        unique case (op[7:4])
          GRP_STOP: begin
            if (op[3:0] == 4'd0) begin
              stateN = ST_IDLE;
            end else begin
              stateN = advState;
              pcN    = advPc;
            end
          end
          GRP_SEL: begin
            csNext = csDecode;
            stateN = advState;
            pcN    = advPc;
          end
          GRP_OUT: begin
            if (txFull) begin
              cmd.consumeTx  = 1'b1;
              cmd.startShift = 1'b1;
              cmd.nBytes     = nb;
              inDirN         = 1'b0;
              stateN         = ST_SHIFT;
            end
          end
          GRP_IN: begin
            cmd.startShift = 1'b1;
            cmd.shiftIn    = 1'b1;
            cmd.nBytes     = nb;
            inDirN         = 1'b1;
            stateN         = ST_SHIFT;
          end
          GRP_BRA: begin
            if (loopCnt != 8'd0) begin
              loopN = loopCnt - 8'd1;
              pcN   = op[2:0];
            end else begin
              stateN = advState;
              pcN    = advPc;
            end
          end
          default: begin
            stateN = advState;
            pcN    = advPc;
          end
        endcase
      end
      ST_SHIFT: begin
        if (shiftDone) begin
          if (inDir) begin
            stateN = ST_RXWAIT;
          end else begin
            stateN = advState;
            pcN    = advPc;
          end
        end
      end
      ST_RXWAIT: begin
        if (!rxFull) begin
          cmd.commitRx = 1'b1;
          stateN       = advState;
          pcN          = advPc;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pc      <= 3'd0;
      loopCnt <= 8'd0;
      inDir   <= 1'b0;
      csReg   <= '1;
    end else if (softRst) begin
      state   <= ST_IDLE;
      pc      <= 3'd0;
      loopCnt <= 8'd0;
      inDir   <= 1'b0;
      csReg   <= '1;
    end else begin
      state   <= stateN;
      pc      <= pcN;
      loopCnt <= loopN;
      inDir   <= inDirN;
      csReg   <= csNext;
    end
  end

  assign seqIdle = (state == ST_IDLE);
  assign csN     = csReg;
endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top
  import spi_seq_pkg::*;
#(
  parameter int CS_COUNT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [2:0]          regAddr,
  input  logic [63:0]         regWrData,
  output logic [63:0]         regRdData,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_COUNT-1:0] csN
);
  seqCmd_t     cmd;
  logic        seqIdle, txFull, rxFull, txOvr, shiftDone, seqWr, softRst;
  logic [63:0] seqWord;
  logic [7:0]  loopInit;

  spi_seq_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regRd     (regRd),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cmd       (cmd),
    .seqIdle   (seqIdle),
    .txFull    (txFull),
    .rxFull    (rxFull),
    .txOvr     (txOvr),
    .shiftDone (shiftDone),
    .seqWr     (seqWr),
    .softRst   (softRst),
    .seqWord   (seqWord),
    .loopInit  (loopInit),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi)
  );

  spi_seq_ctrl #(.CS_COUNT(CS_COUNT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .softRst   (softRst),
    .seqWr     (seqWr),
    .seqWord   (seqWord),
    .loopInit  (loopInit),
    .txFull    (txFull),
    .rxFull    (rxFull),
    .shiftDone (shiftDone),
    .cmd       (cmd),
    .seqIdle   (seqIdle),
    .csN       (csN)
  );
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
  parameter int CS_COUNT = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                sck,
  input logic                mosi,
  input logic [CS_COUNT-1:0] csN,
  input logic                seqIdle,
  input logic                txFull,
  input logic                rxFull,
  input logic                txOvr,
  input logic                softRst
);
  AST_CS_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1); // R4

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi)); // R5

  AST_TXFULL_FALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txFull) && !$past(softRst)) |-> !seqIdle); // R5

  AST_RXFULL_RISE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> !$past(seqIdle)); // R7

  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    seqIdle |-> !sck); // R9

  AST_TX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (txOvr && !softRst) |=> txOvr); // R2

  AST_RST_RELEASE_CS: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (&csN)); // R11
endmodule

bind spi_seq_top spi_seq_chk #(.CS_COUNT(CS_COUNT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sck     (sck),
  .mosi    (mosi),
  .csN     (csN),
  .seqIdle (seqIdle),
  .txFull  (txFull),
  .rxFull  (rxFull),
  .txOvr   (txOvr),
  .softRst (softRst)
);

// File: tb/sim_spi_seq_top.sv
module sim_spi_seq_top;
  localparam int CSN = 4;
  localparam logic [2:0] A_CNT = 3'd0, A_CLK = 3'd1, A_TX = 3'd2,
                         A_RX = 3'd3, A_SEQ = 3'd4, A_STAT = 3'd5;
  localparam logic [63:0] S_IDLE = 64'h0001_0000_0000_0000;
  localparam logic [63:0] S_BUSY = 64'h0002_0000_0000_0000;
  localparam logic [63:0] S_TXF  = 64'h0800_0000_0000_0000;
  localparam logic [63:0] S_TXO  = 64'h0400_0000_0000_0000;
  localparam logic [63:0] S_RXF  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] S_RXU  = 64'h2000_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic sck, mosi, miso;
  logic [CSN-1:0] csN;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  // Bench-side device model
  logic        benchArm = 1'b0;
  logic [63:0] slvNew = '0;
  logic [63:0] slvPat;
  logic [63:0] capBits;
  int          capCnt;
  logic [CSN-1:0] csSeen;
  int          hiCnt = 0;
  int          lastHigh = 0;

  always #2 clk = ~clk;

  spi_seq_top #(.CS_COUNT(CSN)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sck(sck), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  assign miso = slvPat[63];

  always @(negedge sck or posedge benchArm) begin
    if (benchArm) slvPat = slvNew;
    else          slvPat = {slvPat[62:0], 1'b0};
  end

  always @(posedge sck or posedge benchArm) begin
    if (benchArm) begin
      capBits = '0;
      capCnt  = 0;
      csSeen  = '1;
    end else begin
      capBits = {capBits[62:0], mosi};
      capCnt  = capCnt + 1;
      csSeen  = csN;
    end
  end

  always @(posedge clk) begin
    if (sck) hiCnt = hiCnt + 1;
    else if (hiCnt != 0) begin
      lastHigh = hiCnt;
      hiCnt = 0;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic arm(input logic [63:0] pat);
    slvNew = pat;
    benchArm = 1'b1;
    #1 benchArm = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic swReset();
    regWrite(A_CLK, 64'h0000_0050_0000_0000);
    regWrite(A_CLK, 64'h0000_00A0_0000_0000);
  endtask

  task automatic setDiv(input logic [11:0] dv, input logic nd);
    regWrite(A_CLK, {dv, nd, 51'b0});
  endtask

  task automatic waitIdle(input string tag);
    logic [63:0] s;
    s = '0;
    for (int i = 0; i < 4000; i++) begin
      regRead(A_STAT, s);
      if (s[48]) break;
    end
    check(tag, {63'b0, s[48]}, 64'd1);
  endtask

  task automatic waitTxEmpty(input string tag);
    logic [63:0] s;
    s = '1;
    for (int i = 0; i < 4000; i++) begin
      regRead(A_STAT, s);
      if (!s[59]) break;
    end
    check(tag, {63'b0, s[59]}, 64'd0);
  endtask

  task automatic tReset();
    logic [63:0] s;
    regRead(A_STAT, s);
    check("R1 status after reset", s, S_IDLE);
    check("R1 csN after reset", 64'(csN), 64'hF);
    check("R1 sck after reset", 64'(sck), 64'd0);
  endtask

  task automatic tHostFlags();
    logic [63:0] s;
    swReset();
    regWrite(A_TX, 64'h1111_1111_1111_1111);
    regRead(A_STAT, s);
    check("R2 tx full set", s, S_IDLE | S_TXF);
    regWrite(A_TX, 64'h2222_2222_2222_2222);
    regRead(A_STAT, s);
    check("R2 overrun set", s, S_IDLE | S_TXF | S_TXO);
    regRead(A_TX, s);
    check("R2 tx value kept", s, 64'h1111_1111_1111_1111);
    regWrite(A_CLK, 64'h0000_00A0_0000_0000);
    regRead(A_STAT, s);
    check("R11 second step alone", s, S_IDLE | S_TXF | S_TXO);
    swReset();
    regRead(A_STAT, s);
    check("R11 full reset clears flags", s, S_IDLE);
    regRead(A_RX, s);
    regRead(A_STAT, s);
    check("R3 rx underrun", s, S_IDLE | S_RXU);
  endtask

  task automatic tTransmit();
    logic [63:0] s;
    swReset();
    setDiv(12'd1, 1'b1);
    arm('0);
    regWrite(A_TX, 64'hA5C3_0F12_3456_789A);
    regWrite(A_SEQ, 64'h1133_1000_0000_0000);
    waitIdle("R9 tx3 idle");
    check("R5 tx3 bit count", 64'(capCnt), 64'd24);
    check("R5 tx3 data", {40'b0, capBits[23:0]}, 64'hA5C30F);
    check("R4 cs1 active", 64'(csSeen), 64'hE);
    check("R4 deselect", 64'(csN), 64'hF);
    check("R10 half period div1", 64'(lastHigh), 64'd2);
    regRead(A_STAT, s);
    check("R5 tx consumed", s, S_IDLE);
  endtask

  task automatic tStall();
    logic [63:0] s;
    swReset();
    arm('0);
    regWrite(A_SEQ, 64'h1232_1000_0000_0000);
    repeat (60) @(posedge clk);
    regRead(A_STAT, s);
    check("R6 stalled busy", s, S_BUSY);
    check("R6 no sck while stalled", 64'(capCnt), 64'd0);
    regWrite(A_SEQ, 64'h1400_0000_0000_0000);
    regRead(A_SEQ, s);
    check("R12 seq write ignored", s, 64'h1232_1000_0000_0000);
    regWrite(A_TX, 64'hBEEF_0000_0000_0000);
    waitIdle("R6 resumes");
    check("R6 data after stall", {48'b0, capBits[15:0]}, 64'hBEEF);
    check("R4 cs2 active", 64'(csSeen), 64'hD);
    check("R10 half period div0", 64'(lastHigh), 64'd1);
  endtask

  task automatic tReceive();
    logic [63:0] s;
    swReset();
    setDiv(12'd2, 1'b1);
    arm(64'h3C5A_0000_0000_0000);
    regWrite(A_SEQ, 64'h1142_1000_0000_0000);
    waitIdle("R7 rx idle");
    regRead(A_STAT, s);
    check("R7 rx full", s, S_IDLE | S_RXF);
    regRead(A_RX, s);
    check("R7 rx right aligned", s, 64'h3C5A);
    check("R10 half period div2", 64'(lastHigh), 64'd3);
    regRead(A_STAT, s);
    check("R3 read clears full", s, S_IDLE);
    regRead(A_RX, s);
    regRead(A_STAT, s);
    check("R3 underrun after empty read", s, S_IDLE | S_RXU);
  endtask

  task automatic tRxStall();
    logic [63:0] s;
    swReset();
    arm(64'h817E_0000_0000_0000);
    regWrite(A_SEQ, 64'h1141_4110_0000_0000);
    repeat (100) @(posedge clk);
    regRead(A_STAT, s);
    check("R7 waits on full rx", s, S_BUSY | S_RXF);
    regRead(A_RX, s);
    check("R7 first byte delayed sample", s, 64'h81);
    waitIdle("R7 second byte idle");
    regRead(A_RX, s);
    check("R7 second byte", s, 64'h7E);
  endtask

  task automatic tLoop();
    logic [63:0] s;
    logic [7:0] bytes [3];
    bytes[0] = 8'h5A; bytes[1] = 8'hA5; bytes[2] = 8'hC3;
    swReset();
    arm('0);
    regWrite(A_CNT, 64'h0000_0002_0000_0000);
    regWrite(A_SEQ, 64'h1131_E110_0000_0000);
    for (int i = 0; i < 3; i++) begin
      regWrite(A_TX, {bytes[i], 56'b0});
      waitTxEmpty("R8 tx consumed in loop");
    end
    waitIdle("R8 loop idle");
    check("R8 three passes", 64'(capCnt), 64'd24);
    check("R8 loop data", {40'b0, capBits[23:0]}, 64'h5AA5C3);
    arm('0);
    regWrite(A_CNT, 64'h0);
    regWrite(A_TX, 64'h9900_0000_0000_0000);
    regWrite(A_SEQ, 64'h1131_E110_0000_0000);
    waitIdle("R8 zero count idle");
    check("R8 zero count one pass", 64'(capCnt), 64'd8);
    regRead(A_STAT, s);
    check("R8 zero count status", s, S_IDLE);
  endtask

  task automatic tOrder();
    logic [63:0] s;
    swReset();
    arm('0);
    regWrite(A_TX, 64'hC300_0000_0000_0000);
    regWrite(A_SEQ, 64'h1277_3110_5566_7788);
    waitIdle("R9 implicit stop idle");
    check("R13 no-ops skipped", 64'(capCnt), 64'd8);
    check("R13 data", {56'b0, capBits[7:0]}, 64'hC3);
    swReset();
    arm('0);
    regWrite(A_TX, 64'h7700_0000_0000_0000);
    regWrite(A_SEQ, 64'h1100_3110_0000_0000);
    waitIdle("R9 stop idle");
    check("R9 stop prevents shift", 64'(capCnt), 64'd0);
    regRead(A_STAT, s);
    check("R9 tx untouched", s, S_IDLE | S_TXF);
    check("R9 stop keeps select", 64'(csN), 64'hE);
    swReset();
    check("R11 reset releases select", 64'(csN), 64'hF);
    arm('0);
    regWrite(A_TX, 64'h0123_4567_89AB_CDEF);
    regWrite(A_SEQ, 64'h1130_1000_0000_0000);
    waitIdle("R5 eight byte idle");
    check("R5 zero length means 8", 64'(capCnt), 64'd64);
    check("R5 eight byte data", capBits, 64'h0123_4567_89AB_CDEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tHostFlags();
    tTransmit();
    tStall();
    tReceive();
    tRxStall();
    tLoop();
    tOrder();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vecs++;
      errs++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule